// File: doc/BRIEF.md
# Priority Interrupt Controller with Selectable Masking Modes

This block selects which pending interrupt the processor should take next. Each maskable source has a programmable 3-bit priority level. The levels are packed two to a byte in a bank of 8-bit priority registers on a simple register bus. A control register on the same bus holds a 2-bit masking mode and the edge polarity of a non-maskable input.

The processor supplies its current mask state: a single global disable bit and a 3-bit level mask. The block returns a request flag, the index of the winning source and that source's level. It does this combinationally from the registered settings and the live request lines.

The non-maskable input is synchronised and edge-detected. It sets a sticky flag that overrides every maskable source until the processor acknowledges it. With default parameters there are 11 priority registers at addresses 0..10, which serve 22 maskable sources, and the control register sits at address 11.

Top module: `ipc_top`

## Requirements
- R1: After reset every priority register reads 0x77 and the control register reads 0x00.
- R2: Bits 7 and 3 of every priority register ignore writes and read 0. Bits 7..3 of the control register read 0.
- R3: Priority register k holds the level of source 2k in bits 6..4 and of source 2k+1 in bits 2..0. The control register holds the mode in bits 1..0 and the NMI edge select in bit 2.
- R4: In mode 00, no maskable request is signalled while `cpu_i`=1. While `cpu_i`=0, any pending source is accepted, including level 0.
- R5: In mode 10, `cpu_i` is ignored. A pending source is accepted only when its level is greater than `cpu_mask`, or when its level is 7.
- R6: Among accepted sources the highest level wins, and ties go to the lowest index. `int_level` reports the winner's level.
- R7: Modes 01 and 11 behave exactly as mode 00.
- R8: With edge select 0, a falling NMI edge sets the NMI flag; with edge select 1, a rising edge sets it. The flag becomes visible after the third rising clock edge following the pin change. The opposite edge has no effect.
- R9: While the NMI flag is set, `int_req`=1, `int_nmi`=1, `int_src`=0 and `int_level`=7, whatever the maskable requests and both masks are.
- R10: A cycle with `nmi_ack`=1 clears the NMI flag, unless a new edge arrives in that same cycle.
- R11: Changing the edge select while the NMI pin is steady does not set the NMI flag.
- R12: With no accepted request and no NMI, `int_req`, `int_src` and `int_level` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 4 | Register address (0..10 priority, 11 control) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| irq_src | input | 22 | Level-sensitive maskable requests |
| nmi_pin | input | 1 | Asynchronous non-maskable input |
| nmi_ack | input | 1 | Clears the NMI flag |
| cpu_i | input | 1 | Global disable bit from the processor |
| cpu_mask | input | 3 | Level mask from the processor |
| int_req | output | 1 | An interrupt is presented |
| int_nmi | output | 1 | The presented interrupt is the NMI |
| int_src | output | 5 | Winning maskable source index |
| int_level | output | 3 | Level of the presented interrupt |

## Verification
The bench concentrates on the comparison at the mask boundary: a level equal to the mask must be refused, level 7 must pass a mask of 7, and level 0 must never pass in level mode. A design using greater-or-equal, or dropping the level-7 exception, would accept or refuse the wrong source. Tie-breaking between equal levels is checked, since a reversed scan would hand the grant to the higher index. The prohibited mode values are checked because a decoder that keys on only one mode bit would apply level masking to them. On the NMI path, the bench checks the exact cycle of the flag, the opposite polarity, and toggling the polarity with a quiet pin; a detector that folds polarity into its stored sample would fire a false NMI there.

// File: rtl/ipc_pkg.sv
`timescale 1ns/1ps
package ipc_pkg;

  typedef logic [2:0] prio_t;

  typedef enum logic [1:0] {
    MODE_GLOBAL  = 2'b00,
    MODE_BAD_A   = 2'b01,
    MODE_LEVELED = 2'b10,
    MODE_BAD_B   = 2'b11
  } ctl_mode_e;

  localparam prio_t      PRIO_TOP   = 3'd7;
  localparam logic [7:0] PRIO_RESET = 8'h77;

  // Only the exact level-mask code selects leveled masking; reserved codes fall back
  function automatic logic uses_levels(input logic [1:0] mode);
    return mode == MODE_LEVELED;
  endfunction

  // Acceptance rule for one pending source
  function automatic logic accepts(input prio_t lvl, input logic leveled,
                                   input logic gbit, input prio_t mask);
    if (leveled) return (lvl > mask) || (lvl == PRIO_TOP);
    else         return !gbit;
  endfunction

  // Read image of a priority byte: reserved bits forced low
  function automatic logic [7:0] prio_image(input prio_t hi, input prio_t lo);
    return {1'b0, hi, 1'b0, lo};
  endfunction

  function automatic logic [7:0] ctrl_image(input logic esel, input logic [1:0] mode);
    return {5'b0, esel, mode};
  endfunction

endpackage

// File: rtl/ipc_regs.sv
`timescale 1ns/1ps
module ipc_regs #(
  parameter  int NUM_REGS = 11,
  parameter  int ADDR_W   = 4,
  localparam int NUM_SRC  = 2 * NUM_REGS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_sel,
  input  logic                   bus_wr,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [7:0]             bus_wdata,
  output logic [7:0]             bus_rdata,
  output logic [3*NUM_SRC-1:0]   prio_flat,
  output logic [1:0]             mode,
  output logic                   edge_sel
);
  import ipc_pkg::*;

  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_REGS);

  logic [7:0] rd_word [NUM_REGS];
  logic       wr_en;

  assign wr_en = bus_sel & bus_wr;

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_prio
    prio_t hi_q, lo_q;
    logic  hit;
    assign hit = wr_en && (bus_addr == ADDR_W'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_q <= PRIO_RESET[6:4];
        lo_q <= PRIO_RESET[2:0];
      end else if (hit) begin
        hi_q <= bus_wdata[6:4];
        lo_q <= bus_wdata[2:0];
      end
    end
    assign prio_flat[3*(2*k)   +: 3] = hi_q;
    assign prio_flat[3*(2*k+1) +: 3] = lo_q;
    assign rd_word[k] = prio_image(hi_q, lo_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= MODE_GLOBAL;
      edge_sel <= 1'b0;
    end else if (wr_en && bus_addr == CTRL_ADDR) begin
      mode     <= bus_wdata[1:0];
      edge_sel <= bus_wdata[2];
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (bus_addr == ADDR_W'(k)) bus_rdata = rd_word[k];
    end
    if (bus_addr == CTRL_ADDR) bus_rdata = ctrl_image(edge_sel, mode);
  end

endmodule

// File: rtl/ipc_nmi.sv
`timescale 1ns/1ps
module ipc_nmi #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic edge_sel,
  input  logic ack,
  output logic synced,
  output logic edge_hit,
  output logic pend
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      pend   <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      prev_q <= sync_q[SYNC_STAGES-1];  // raw sample history, polarity-free
      pend   <= edge_hit | (pend & ~ack);
    end
  end

  assign synced   = sync_q[SYNC_STAGES-1];
  assign edge_hit = edge_sel ? (synced & ~prev_q) : (~synced & prev_q);

endmodule

// File: rtl/ipc_arb.sv
`timescale 1ns/1ps
module ipc_arb #(
  parameter  int NUM_SRC = 22,
  localparam int SRC_W   = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]   irq,
  input  logic [3*NUM_SRC-1:0] prio_flat,
  input  logic                 leveled,
  input  logic                 gbit,
  input  logic [2:0]           mask,
  output logic                 win_valid,
  output logic [SRC_W-1:0]     win_idx,
  output logic [2:0]           win_lvl
);
  import ipc_pkg::*;

  logic [NUM_SRC-1:0] ok;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_ok
    assign ok[s] = irq[s] && accepts(prio_flat[3*s +: 3], leveled, gbit, mask);
  end

  // Ascending scan with strict compare keeps the lowest index on ties
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_lvl   = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (ok[s] && (!win_valid || prio_flat[3*s +: 3] > win_lvl)) begin
        win_valid = 1'b1;
        win_idx   = SRC_W'(s);
        win_lvl   = prio_flat[3*s +: 3];
      end
    end
  end

endmodule

// File: rtl/ipc_top.sv
`timescale 1ns/1ps
module ipc_top #(
  parameter  int NUM_REGS = 11,
  parameter  int ADDR_W   = 4,
  localparam int NUM_SRC  = 2 * NUM_REGS,
  localparam int SRC_W    = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [7:0]         bus_wdata,
  output logic [7:0]         bus_rdata,
  input  logic [NUM_SRC-1:0] irq_src,
  input  logic               nmi_pin,
  input  logic               nmi_ack,
  input  logic               cpu_i,
  input  logic [2:0]         cpu_mask,
  output logic               int_req,
  output logic               int_nmi,
  output logic [SRC_W-1:0]   int_src,
  output logic [2:0]         int_level
);
  import ipc_pkg::*;

  logic [3*NUM_SRC-1:0] prio_flat;
  logic [1:0]           ctl_mode;
  logic                 ctl_esel;
  logic                 nmi_sync, nmi_edge, nmi_pend;
  logic                 arb_valid;
  logic [SRC_W-1:0]     arb_idx;
  logic [2:0]           arb_lvl;

  ipc_regs #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .prio_flat(prio_flat), .mode(ctl_mode), .edge_sel(ctl_esel)
  );

  ipc_nmi #(.SYNC_STAGES(2)) u_nmi (
    .clk(clk), .rst_n(rst_n), .pin(nmi_pin), .edge_sel(ctl_esel),
    .ack(nmi_ack), .synced(nmi_sync), .edge_hit(nmi_edge), .pend(nmi_pend)
  );

  ipc_arb #(.NUM_SRC(NUM_SRC)) u_arb (
    .irq(irq_src), .prio_flat(prio_flat), .leveled(uses_levels(ctl_mode)),
    .gbit(cpu_i), .mask(cpu_mask), .win_valid(arb_valid),
    .win_idx(arb_idx), .win_lvl(arb_lvl)
  );

  always_comb begin
    int_nmi   = nmi_pend;
    int_req   = nmi_pend | arb_valid;
    int_src   = '0;
    int_level = '0;
    if (nmi_pend) begin
      int_level = PRIO_TOP;
    end else if (arb_valid) begin
      int_src   = arb_idx;
      int_level = arb_lvl;
    end
  end

endmodule

// File: rtl/ipc_chk.sv
`timescale 1ns/1ps
module ipc_chk #(
  parameter int NUM_REGS = 11,
  parameter int ADDR_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_rdata,
  input logic              cpu_i,
  input logic [2:0]        cpu_mask,
  input logic              nmi_ack,
  input logic              int_req,
  input logic              int_nmi,
  input logic [2:0]        int_level,
  input logic [1:0]        mode,
  input logic              esel,
  input logic              nmi_sync,
  input logic              nmi_edge,
  input logic              nmi_pend
);
  localparam logic [ADDR_W-1:0] N_PRIO = ADDR_W'(NUM_REGS);

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr < N_PRIO) |-> (bus_rdata[7] == 1'b0 && bus_rdata[3] == 1'b0));

  a_r4_gbit_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b10 && cpu_i && !int_nmi) |-> !int_req);

  a_r5_level_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && int_req && !int_nmi) |-> (int_level > cpu_mask || int_level == 3'd7));

  a_r9_nmi_override: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pend |-> (int_req && int_nmi && int_level == 3'd7));

  a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_pend && nmi_ack && !nmi_edge) |=> !nmi_pend);

  a_r11_esel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(esel) && $stable(nmi_sync)) |-> !nmi_edge);

endmodule

bind ipc_top ipc_chk #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .cpu_i(cpu_i), .cpu_mask(cpu_mask), .nmi_ack(nmi_ack), .int_req(int_req),
  .int_nmi(int_nmi), .int_level(int_level), .mode(ctl_mode), .esel(ctl_esel),
  .nmi_sync(nmi_sync), .nmi_edge(nmi_edge), .nmi_pend(nmi_pend)
);

// File: tb/sim_ipc_top.sv
`timescale 1ns/1ps
module sim_ipc_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [21:0] irq_src = '0;
  logic        nmi_pin = 1'b0, nmi_ack = 1'b0, cpu_i = 1'b0;
  logic [2:0]  cpu_mask = '0;
  logic        int_req, int_nmi;
  logic [4:0]  int_src;
  logic [2:0]  int_level;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  ipc_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_src(irq_src), .nmi_pin(nmi_pin), .nmi_ack(nmi_ack), .cpu_i(cpu_i),
    .cpu_mask(cpu_mask), .int_req(int_req), .int_nmi(int_nmi),
    .int_src(int_src), .int_level(int_level)
  );

  typedef struct packed {
    logic [3:0]  rq;
    logic [1:0]  mode;
    logic        gbit;
    logic [2:0]  mask;
    logic [21:0] src;
    logic        req;
    logic [4:0]  win;
    logic [2:0]  lvl;
  } vec_t;

  // Programmed levels: src0=3 src1=5 src2=5 src3=2 src4=7 src5=0, others 7
  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{4'd4,  2'b00, 1'b0, 3'd0, 22'h000001, 1'b1, 5'd0,  3'd3}, // R4 single source
    '{4'd4,  2'b00, 1'b1, 3'd0, 22'h000003, 1'b0, 5'd0,  3'd0}, // R4 global bit blocks
    '{4'd6,  2'b00, 1'b0, 3'd0, 22'h00000B, 1'b1, 5'd1,  3'd5}, // R6 highest level
    '{4'd6,  2'b00, 1'b0, 3'd0, 22'h000006, 1'b1, 5'd1,  3'd5}, // R6 tie, low index
    '{4'd5,  2'b10, 1'b0, 3'd4, 22'h000009, 1'b0, 5'd0,  3'd0}, // R5 below mask
    '{4'd5,  2'b10, 1'b0, 3'd4, 22'h000003, 1'b1, 5'd1,  3'd5}, // R5 above mask
    '{4'd5,  2'b10, 1'b0, 3'd7, 22'h000012, 1'b1, 5'd4,  3'd7}, // R5 level 7 passes mask 7
    '{4'd5,  2'b10, 1'b0, 3'd0, 22'h000020, 1'b0, 5'd0,  3'd0}, // R5 level 0 never passes
    '{4'd5,  2'b10, 1'b1, 3'd2, 22'h000001, 1'b1, 5'd0,  3'd3}, // R5 global bit ignored
    '{4'd7,  2'b01, 1'b1, 3'd0, 22'h000001, 1'b0, 5'd0,  3'd0}, // R7 code 01 as global
    '{4'd7,  2'b11, 1'b0, 3'd7, 22'h000008, 1'b1, 5'd3,  3'd2}, // R7 code 11 ignores mask; R3 low field
    '{4'd6,  2'b00, 1'b0, 3'd0, 22'h300000, 1'b1, 5'd20, 3'd7}, // R6 tie at top indices
    '{4'd4,  2'b00, 1'b0, 3'd0, 22'h000020, 1'b1, 5'd5,  3'd0}, // R4 level 0 accepted
    '{4'd5,  2'b10, 1'b0, 3'd6, 22'h200020, 1'b1, 5'd21, 3'd7}, // R5 last source
    '{4'd12, 2'b00, 1'b0, 3'd0, 22'h000000, 1'b0, 5'd0,  3'd0}  // R12 idle outputs
  };

  task automatic chk(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic check_out(input string rq, input logic r, input logic n,
                           input logic [4:0] s, input logic [2:0] l);
    chk(rq, "int_req", int_req, r);
    chk(rq, "int_nmi", int_nmi, n);
    chk(rq, "int_src", int_src, s);
    chk(rq, "int_level", int_level, l);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    for (int k = 0; k < 11; k++) begin
      bus_read(4'(k), rd);
      chk("R1", "prio reset", rd, 8'h77);
    end
    bus_read(4'd11, rd);
    chk("R1", "ctrl reset", rd, 8'h00);
    #1 check_out("R12", 1'b0, 1'b0, 5'd0, 3'd0);

    // R2 reserved bits
    bus_write(4'd7, 8'hFF);
    bus_read(4'd7, rd);
    chk("R2", "prio all ones", rd, 8'h77);
    bus_write(4'd7, 8'h88);
    bus_read(4'd7, rd);
    chk("R2", "prio reserved only", rd, 8'h00);
    bus_write(4'd7, 8'h77);
    bus_write(4'd11, 8'hFB);
    bus_read(4'd11, rd);
    chk("R2", "ctrl upper bits", rd, 8'h03);
    bus_write(4'd11, 8'h00);

    // R3 field placement used by the vector table
    bus_write(4'd0, 8'h35);
    bus_write(4'd1, 8'h52);
    bus_write(4'd2, 8'h70);
    bus_read(4'd1, rd);
    chk("R3", "prio readback", rd, 8'h52);

    for (int v = 0; v < NV; v++) begin
      bus_write(4'd11, {6'b0, VECS[v].mode});
      @(negedge clk);
      cpu_i = VECS[v].gbit; cpu_mask = VECS[v].mask; irq_src = VECS[v].src;
      #1;
      check_out($sformatf("R%0d", VECS[v].rq), VECS[v].req, 1'b0, VECS[v].win, VECS[v].lvl);
    end

    // NMI tests: falling select, sources active and globally masked
    bus_write(4'd11, 8'h00);
    @(negedge clk);
    irq_src = 22'h000001; cpu_i = 1'b1;
    nmi_pin = 1'b1;                            // R8 rising edge, wrong polarity
    wait_neg(5);
    chk("R8", "rising ignored", int_nmi, 1'b0);
    @(negedge clk);
    nmi_pin = 1'b0;                            // R8 falling edge
    wait_neg(2);
    chk("R8", "not yet after two edges", int_nmi, 1'b0);
    wait_neg(1);
    chk("R8", "flag after third edge", int_nmi, 1'b1);
    check_out("R9", 1'b1, 1'b1, 5'd0, 3'd7);
    @(negedge clk);
    cpu_i = 1'b0; bus_write(4'd11, 8'h02); @(negedge clk); cpu_mask = 3'd7;
    #1 check_out("R9", 1'b1, 1'b1, 5'd0, 3'd7);
    @(negedge clk);
    nmi_ack = 1'b1;
    @(negedge clk);
    nmi_ack = 1'b0;
    #1 chk("R10", "ack clears", int_nmi, 1'b0);
    irq_src = '0;
    wait_neg(3);
    chk("R10", "stays clear", int_nmi, 1'b0);

    // R11 flip polarity with a steady low pin
    bus_write(4'd11, 8'h04);
    wait_neg(4);
    chk("R11", "select change quiet", int_nmi, 1'b0);
    chk("R11", "select change no req", int_req, 1'b0);

    // R8 rising edge with select 1
    @(negedge clk);
    nmi_pin = 1'b1;
    wait_neg(3);
    chk("R8", "rising flagged", int_nmi, 1'b1);
    @(negedge clk);
    nmi_ack = 1'b1;
    @(negedge clk);
    nmi_ack = 1'b0;
    // R11 flip back with a steady high pin
    bus_write(4'd11, 8'h00);
    wait_neg(4);
    chk("R11", "select change high pin", int_nmi, 1'b0);
    bus_write(4'd11, 8'h04);
    @(negedge clk);
    nmi_pin = 1'b0;                            // R8 falling edge with select 1
    wait_neg(5);
    chk("R8", "falling ignored", int_nmi, 1'b0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule